// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Recording

This block is a free-running up-counter that resets the system if software stops servicing it. After any reset it starts at zero and counts on a prescaled clock. There are two prescale choices, a divide-by-2 rate and a divide-by-128 rate. If the count wraps past its top value, the block pulses a reset request, restarts from zero and remembers that the watchdog caused the reset. Software keeps the system alive by issuing a service strobe. The service strobe reloads the upper byte of the count from a programmable reload field and clears the lower byte.

The block also records what caused the last resets. The sources are a short hardware reset, a long hardware reset or undervoltage, a software reset and a watchdog overflow. These flags accumulate, so several can read as set at once. An end-of-initialization strobe clears them all.

A disable strobe can switch the watchdog off. It is honoured only in the window between a reset and the first service or end-of-initialization strobe. Once that window is closed, only a new reset reopens it. Decoding of the CPU commands and of the bus address happens outside this block.

Top module: `wdog_core`

## Requirements
- R1: While `rst` is high and after it falls, the outputs read as follows until the first prescaled tick: `count_o` is 0, `ctrl_o` is 0 and `wdt_rst_o` is 0. The watchdog starts enabled.
- R2: The select bit is `ctrl_o[0]`. When it is 0, `count_o` rises by one every 2 clocks, and the first increment comes 2 clocks after a reset event or a restart. When it is 1, `count_o` rises by one every 128 clocks.
- R3: A service strobe sets `count_o` to {reload field, 8'h00} on the next clock and restarts the prescaler. It also clears the watchdog flag in `ctrl_o[1]`.
- R4: When a tick arrives while `count_o` is 16'hFFFF, the following happens on the next clock. `count_o` reads 0 and `ctrl_o[1]` sets. The reload field and the select bit clear. `wdt_rst_o` is high for exactly one clock.
- R5: Each reset source sets its own flag in `ctrl_o`: a short hardware reset sets bit 3, a long hardware reset or undervoltage sets bit 4, and a software reset sets bit 2. Flags accumulate. Each of these events also clears the count to 0, enables the watchdog, and clears the reload field and the select bit.
- R6: An end-of-initialization strobe clears `ctrl_o[4:1]`.
- R7: A disable strobe stops the count and prevents any overflow. It has this effect only if no service or end-of-initialization strobe has come since the last reset. After either of those strobes, a disable strobe has no effect.
- R8: After a disable, the next reset event enables the watchdog again, and it counts from 0.
- R9: A register write places `wdata_i[15:8]` into the reload field (`ctrl_o[15:8]`) and `wdata_i[0]` into the select bit. Written values on bits 7:1 are ignored, and `ctrl_o[7:5]` reads 0.
- R10: A write that changes the select bit restarts the prescaler from zero. A write that keeps the same select value leaves the prescale phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on initialization |
| sw_rst_i | input | 1 | Software reset strobe |
| hw_short_i | input | 1 | Short hardware reset event |
| hw_long_i | input | 1 | Long hardware reset event |
| uv_i | input | 1 | Undervoltage reset event |
| svc_i | input | 1 | Service strobe |
| einit_i | input | 1 | End-of-initialization strobe |
| dis_i | input | 1 | Disable request strobe |
| wr_en_i | input | 1 | Control register write enable |
| wdata_i | input | 16 | Control register write data |
| ctrl_o | output | 16 | Control/status register read value |
| count_o | output | 16 | Current count value |
| wdt_rst_o | output | 1 | One-clock reset request on overflow |

## Verification
The bench sweeps five reload values and checks the count after every clock on the divide-by-2 rate. A design that loaded the wrong byte, or that did not restart the prescaler on service, would be off by one tick within a few cycles. The bench drives the count to 16'hFFFF and checks it on the cycle before and the cycle after the wrap. A late or stretched reset request would show there, and so would a reload field that survives the overflow. It issues the disable strobe both inside the window after reset and after a service or end-of-initialization strobe has closed it, which catches a design whose window never closes or never reopens. Finally, it writes the select bit mid-period, once with a change and once with the same value, which catches a prescaler that restarts on every write or never restarts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Flag positions inside the control/status word
  localparam int SEL_BIT   = 0;
  localparam int FLG_WDT   = 1;
  localparam int FLG_SW    = 2;
  localparam int FLG_SHORT = 3;
  localparam int FLG_LONG  = 4;
  localparam int N_FLAGS   = 4;

  // Reset causes, ordered to match flag bits 4:1
  typedef struct packed {
    logic lng;
    logic shrt;
    logic sw;
    logic wdt;
  } rst_cause_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,     // restart phase (reset events, service, select change)
  input  logic gate_i,    // suppress the tick of a restarting cycle
  input  logic en_i,      // watchdog running
  input  logic sel_i,     // 0: fast divider, 1: slow divider
  output logic tick_o
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PW      = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;
  logic          at_lim;

  assign lim    = sel_i ? LIM_SLOW : LIM_FAST;
  assign at_lim = (pre_q == lim);
  assign tick_o = en_i & ~gate_i & at_lim;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      pre_q <= '0;
    else if (en_i)
      pre_q <= at_lim ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16,
  parameter int REL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [REL_W-1:0] rel_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int LOW_W = CNT_W - REL_W;

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= {rel_i, {LOW_W{1'b0}}};
    else if (tick_i)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int REL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst_i,
  input  logic             hw_short_i,
  input  logic             hw_long_i,
  input  logic             uv_i,
  input  logic             ovf_i,
  input  logic             svc_i,
  input  logic             einit_i,
  input  logic             dis_i,
  input  logic             wr_en_i,
  input  logic [REL_W-1:0] wrel_i,
  input  logic             wsel_i,
  output logic [REL_W-1:0] rel_o,
  output logic             sel_o,
  output rst_cause_t       flags_o,
  output logic             run_o,
  output logic             req_o,
  output logic             ext_ev_o,
  output logic             svc_ok_o,
  output logic             sel_chg_o
);
  logic [REL_W-1:0] rel_q;
  logic             sel_q;
  rst_cause_t       flg_q;
  logic             run_q;
  logic             win_q;
  logic             req_q;

  logic any_ev, einit_ok, wr_ok, dis_ok;

  // External reset sources never depend on the tick, so these stay loop-free
  assign ext_ev_o  = sw_rst_i | hw_short_i | hw_long_i | uv_i;
  assign any_ev    = ext_ev_o | ovf_i;
  assign svc_ok_o  = svc_i & ~ext_ev_o;
  assign einit_ok  = einit_i & ~ext_ev_o;
  assign wr_ok     = wr_en_i & ~ext_ev_o;
  assign sel_chg_o = wr_ok & (wsel_i != sel_q);
  assign dis_ok    = dis_i & win_q & ~svc_i & ~einit_i & ~any_ev;

  assign rel_o   = rel_q;
  assign sel_o   = sel_q;
  assign flags_o = flg_q;
  assign run_o   = run_q;
  assign req_o   = req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q <= '0;
      sel_q <= 1'b0;
      flg_q <= '0;
      run_q <= 1'b1;
      win_q <= 1'b1;
      req_q <= 1'b0;
    end else begin
      req_q <= ovf_i;
      if (any_ev) begin
        rel_q      <= '0;
        sel_q      <= 1'b0;
        run_q      <= 1'b1;
        win_q      <= 1'b1;
        flg_q.lng  <= flg_q.lng  | hw_long_i | uv_i;
        flg_q.shrt <= flg_q.shrt | hw_short_i;
        flg_q.sw   <= flg_q.sw   | sw_rst_i;
        flg_q.wdt  <= flg_q.wdt  | ovf_i;
      end else begin
        if (svc_ok_o) begin
          win_q     <= 1'b0;
          flg_q.wdt <= 1'b0;
        end
        if (einit_ok) begin
          win_q <= 1'b0;
          flg_q <= '0;
        end
        if (dis_ok)
          run_q <= 1'b0;
        if (wr_ok) begin
          rel_q <= wrel_i;
          sel_q <= wsel_i;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int REL_W    = 8,
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst_i,
  input  logic             hw_short_i,
  input  logic             hw_long_i,
  input  logic             uv_i,
  input  logic             svc_i,
  input  logic             einit_i,
  input  logic             dis_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic             wdt_rst_o
);
  localparam int LOW_W = CNT_W - REL_W;
  localparam int PAD_W = LOW_W - (N_FLAGS + 1);

  logic [REL_W-1:0] rel;
  logic             sel;
  rst_cause_t       flags;
  logic             run_q;
  logic             ext_ev, svc_ok, sel_chg;
  logic             tick, ovf;
  logic             unused_wbits;

  assign unused_wbits = ^wdata_i[LOW_W-1:1];

  wdog_ctrl #(.REL_W(REL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sw_rst_i  (sw_rst_i),
    .hw_short_i(hw_short_i),
    .hw_long_i (hw_long_i),
    .uv_i      (uv_i),
    .ovf_i     (ovf),
    .svc_i     (svc_i),
    .einit_i   (einit_i),
    .dis_i     (dis_i),
    .wr_en_i   (wr_en_i),
    .wrel_i    (wdata_i[CNT_W-1:LOW_W]),
    .wsel_i    (wdata_i[SEL_BIT]),
    .rel_o     (rel),
    .sel_o     (sel),
    .flags_o   (flags),
    .run_o     (run_q),
    .req_o     (wdt_rst_o),
    .ext_ev_o  (ext_ev),
    .svc_ok_o  (svc_ok),
    .sel_chg_o (sel_chg)
  );

  wdog_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr_i (ext_ev | ovf | svc_ok | sel_chg),
    .gate_i(svc_ok | sel_chg),
    .en_i  (run_q),
    .sel_i (sel),
    .tick_o(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (ext_ev | ovf),
    .load_i(svc_ok),
    .rel_i (rel),
    .tick_i(tick),
    .cnt_o (count_o),
    .wrap_o(ovf)
  );

  assign ctrl_o = {rel, {PAD_W{1'b0}}, flags, sel};
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
  parameter int CNT_W = 16,
  parameter int REL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_rst_i,
  input logic             hw_short_i,
  input logic             hw_long_i,
  input logic             uv_i,
  input logic             svc_i,
  input logic             einit_i,
  input logic [CNT_W-1:0] ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             wdt_rst_o,
  input logic             run_q,
  input logic             ovf
);
  localparam int LOW_W = CNT_W - REL_W;

  logic ext;
  assign ext = sw_rst_i | hw_short_i | hw_long_i | uv_i;

  // R4
  rst_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |=> !wdt_rst_o);

  // R4
  wrap_state_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |-> (count_o == '0 && ctrl_o[1] && ctrl_o[CNT_W-1:LOW_W] == '0));

  // R3
  service_load_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_i && !ext) |=> (count_o[CNT_W-1:LOW_W] == $past(ctrl_o[CNT_W-1:LOW_W])
                         && count_o[LOW_W-1:0] == '0 && !ctrl_o[1]));

  // R6
  einit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (einit_i && !ext && !ovf) |=> (ctrl_o[4:1] == 4'b0000));

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ext && !svc_i) |=> $stable(count_o));

  // R5
  short_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hw_short_i |=> (ctrl_o[3] && count_o == '0));
endmodule

bind wdog_core wdog_core_chk #(.CNT_W(CNT_W), .REL_W(REL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_rst_i  (sw_rst_i),
  .hw_short_i(hw_short_i),
  .hw_long_i (hw_long_i),
  .uv_i      (uv_i),
  .svc_i     (svc_i),
  .einit_i   (einit_i),
  .ctrl_o    (ctrl_o),
  .count_o   (count_o),
  .wdt_rst_o (wdt_rst_o),
  .run_q     (run_q),
  .ovf       (ovf)
);

// File: tb/wdog_core_test.sv
`timescale 1ns/1ps
module wdog_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_rst_i = 0, hw_short_i = 0, hw_long_i = 0, uv_i = 0;
  logic        svc_i = 0, einit_i = 0, dis_i = 0, wr_en_i = 0;
  logic [15:0] wdata_i = '0;
  logic [15:0] ctrl_o, count_o;
  logic        wdt_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int S_SW = 0, S_SHORT = 1, S_LONG = 2, S_UV = 3,
                 S_SVC = 4, S_EINIT = 5, S_DIS = 6;

  always #2.5 clk = ~clk;

  wdog_core uut (
    .clk(clk), .rst(rst), .sw_rst_i(sw_rst_i), .hw_short_i(hw_short_i),
    .hw_long_i(hw_long_i), .uv_i(uv_i), .svc_i(svc_i), .einit_i(einit_i),
    .dis_i(dis_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .ctrl_o(ctrl_o), .count_o(count_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobe(input int which);
    case (which)
      S_SW:    sw_rst_i   = 1'b1;
      S_SHORT: hw_short_i = 1'b1;
      S_LONG:  hw_long_i  = 1'b1;
      S_UV:    uv_i       = 1'b1;
      S_SVC:   svc_i      = 1'b1;
      S_EINIT: einit_i    = 1'b1;
      default: dis_i      = 1'b1;
    endcase
    step(1);
    {sw_rst_i, hw_short_i, hw_long_i, uv_i, svc_i, einit_i, dis_i} = '0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en_i = 1'b1;
    wdata_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  initial begin
    logic [7:0] rels [5] = '{8'h00, 8'h01, 8'h37, 8'h80, 8'hFE};
    step(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 ctrl", ctrl_o, 0);
    check("R1 req", wdt_rst_o, 0);
    // R2 fast rate sweep from reset
    for (int m = 1; m <= 20; m++) begin
      step(1);
      check("R2 fast count", count_o, m / 2);
    end
    // R5 reset sources and accumulation
    strobe(S_SHORT);
    check("R5 short flag", ctrl_o, 16'h0008);
    check("R5 short clears count", count_o, 0);
    step(7);
    check("R5 count after short", count_o, 3);
    strobe(S_LONG);
    check("R5 long flag", ctrl_o, 16'h0018);
    strobe(S_SW);
    check("R5 sw flag accumulates", ctrl_o, 16'h001C);
    // R6 end of initialization clears flags
    strobe(S_EINIT);
    check("R6 flags cleared", ctrl_o, 16'h0000);
    strobe(S_UV);
    check("R5 undervoltage flag", ctrl_o, 16'h0010);
    wr(16'h3300);
    check("R9 reload write", ctrl_o, 16'h3310);
    strobe(S_SW);
    check("R5 reset clears reload", ctrl_o, 16'h0014);
    // R9 read-only and reserved bits
    wr(16'hFFFE);
    check("R9 flag bits ignored", ctrl_o, 16'hFF14);
    // R3 service with several reload values
    foreach (rels[i]) begin
      wr({rels[i], 8'h00});
      strobe(S_SVC);
      check("R3 service load", count_o, {rels[i], 8'h00});
      for (int m = 1; m <= 9; m++) begin
        step(1);
        check("R3 count after service", count_o, {rels[i], 8'h00} + m / 2);
      end
    end
    // R7 disable after service is ignored
    strobe(S_DIS);
    step(10);
    check("R7 disable ignored after service", count_o, 16'hFE0A);
    // R4 overflow
    wr(16'hFF00);
    strobe(S_SVC);
    step(511);
    check("R4 top value", count_o, 16'hFFFF);
    check("R4 no early req", wdt_rst_o, 0);
    step(1);
    check("R4 wrap count", count_o, 0);
    check("R4 req pulse", wdt_rst_o, 1);
    check("R4 flag and cleared reload", ctrl_o, 16'h0016);
    step(1);
    check("R4 req one clock", wdt_rst_o, 0);
    strobe(S_SVC);
    check("R3 service clears wdt flag", ctrl_o, 16'h0014);
    // R7 disable inside the window
    strobe(S_SW);
    strobe(S_DIS);
    step(300);
    check("R7 disabled count holds", count_o, 0);
    check("R7 disabled no req", wdt_rst_o, 0);
    // R8 re-enable through reset
    strobe(S_SW);
    step(4);
    check("R8 counting again", count_o, 2);
    // R7 disable after end of initialization is ignored
    strobe(S_SW);
    strobe(S_EINIT);
    strobe(S_DIS);
    step(6);
    check("R7 disable ignored after einit", count_o, 4);
    // R10 select change restarts, same select does not
    strobe(S_SW);
    step(1);
    wr(16'h0001);
    check("R10 sel set", ctrl_o, 16'h0005);
    check("R10 count after sel write", count_o, 0);
    step(127);
    check("R2 slow no early tick", count_o, 0);
    step(1);
    check("R2 slow tick", count_o, 1);
    step(127);
    check("R2 slow hold", count_o, 1);
    step(1);
    check("R2 slow second tick", count_o, 2);
    step(64);
    wr(16'h0001);
    step(62);
    check("R10 same sel keeps phase pre", count_o, 2);
    step(1);
    check("R10 same sel keeps phase", count_o, 3);
    wr(16'h0000);
    step(1);
    check("R10 back to fast pre", count_o, 3);
    step(1);
    check("R10 back to fast tick", count_o, 4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule